// File: doc/BRIEF.md
# Four-Channel DMA Controller Register File

This block is the host-facing register file of a four-channel, byte-wide DMA controller. Software talks to it through an 8-bit I/O port with a 4-bit port address. Through that port it programs each channel's 16-bit start address and 16-bit count, writes a per-channel mode byte, and masks or unmasks channels. It can also clear the shared byte pointer and read a status byte. The 16-bit registers go through the 8-bit port one byte at a time. A single pointer flip-flop, shared by every channel, selects which byte an access reaches.

A separate transfer engine sits beside the block. The block gives it each channel's programmed base values, mode and mask, plus the request lines with masked channels removed. The engine returns a one-cycle step pulse for each transfer it completes. On each step the block advances that channel's current address and count. It detects terminal count, raises a terminal-count pulse, latches a status flag, and then either reloads the channel (auto-initialize) or masks it.

Port map: channel *n* has its address at port 2n and its count at port 2n+1. Port 8 is status (read). Port 9 is single mask, port 10 is mode, port 11 clears the pointer, and port 12 is the all-mask register, which can be written and read.

Top module: `dmac_regfile`

## Requirements
- R1: After reset all four mask bits are 1, all base and current registers are 0, the status flags are 0 and the byte pointer selects the low byte.
- R2: A write to port 2n (address) or 2n+1 (count) loads the byte selected by the pointer into both the base copy and the current copy of channel n. Base values appear on `ch_base_addr` and `ch_base_count`, channel n in bits [16n+15:16n].
- R3: A write of any value to port 11 returns the byte pointer to the low byte.
- R4: Every read or write of ports 0 to 7 toggles the one shared byte pointer, low byte first. A read returns the selected byte of the current copy, not the base copy.
- R5: A write to port 9 changes one mask bit. Data bits [1:0] give the channel, and bit 2 sets the mask (1) or clears it (0).
- R6: A write to port 12 loads all four mask bits from data bits [3:0], ignoring bits [7:4]. A read of port 12 returns the mask in bits [3:0].
- R7: A write to port 10 stores data bits [7:2] as the mode of the channel named in bits [1:0]. Those bits are: [3:2] direction (01 write, 10 read), [4] auto-initialize, [5] address decrement, [7:6] transfer type (00 demand, 01 single, 10 block, 11 cascade). The stored 6 bits appear on `ch_mode`, channel n in bits [6n+5:6n].
- R8: A step pulse adds one to the current address, or subtracts one when the decrement bit is set, and subtracts one from the current count. The base copies are left unchanged.
- R9: The count holds length minus one. A step taken while the current count is 0 is the terminal step: `ch_tc` pulses in that same cycle, and the channel's status flag is set from the next cycle.
- R10: A read of port 8 returns the terminal-count flags in bits [3:0] and the unmasked requests in bits [7:4], then clears the flags. A flag set in the same cycle as the read survives.
- R11: On the terminal step, a channel with auto-initialize set reloads its current address and count from base and keeps its mask. A channel without it counts through zero and has its mask bit set.
- R12: `ch_req_ok` carries `ch_req` only for channels whose mask bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| io_cs | input | 1 | Port select |
| io_wr | input | 1 | Write strobe, one cycle |
| io_rd | input | 1 | Read strobe, one cycle |
| io_addr | input | 4 | Port address |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, valid in the strobe cycle |
| ch_base_addr | output | 64 | Base addresses, 16 bits per channel |
| ch_base_count | output | 64 | Base counts, 16 bits per channel |
| ch_mask | output | 4 | Mask bit per channel |
| ch_mode | output | 24 | Mode, 6 bits per channel |
| ch_req | input | 4 | Raw request per channel |
| ch_req_ok | output | 4 | Requests of unmasked channels |
| ch_step | input | 4 | Transfer-done pulse from the engine |
| ch_tc | output | 4 | Terminal-count pulse |

## Verification
A byte pointer out of step shows up on the very next 16-bit access: the read returns the wrong byte, or a write lands in the wrong half of the register. A wrong current counter stays hidden until a readback, or until terminal count arrives one step early or late. That misplaced step moves the `ch_tc` pulse, the status flag and the mask change together. A status flag that is not cleared, or that is lost, shows on the next read of port 8. The bench therefore places reads directly after each step and each pointer operation, and puts a status read in the same cycle as a terminal step.

// File: rtl/dmac_pkg.sv
// Shared constants and the mode record for the DMA register file.
// Assumes four channels, 16-bit words and a 4-bit port address.
package dmac_pkg;
    localparam int NCH    = 4;
    localparam int WORD_W = 16;

    // Mode fields as stored (bits [7:2] of the mode byte).
    typedef struct packed {
        logic [1:0] xfer;      // 00 demand, 01 single, 10 block, 11 cascade
        logic       down;      // address decrement
        logic       autoinit;  // reload from base on terminal count
        logic [1:0] dir;       // 01 write, 10 read
    } mode_t;

    localparam int MODE_W = $bits(mode_t);

    localparam logic [3:0] PORT_STATUS = 4'h8;
    localparam logic [3:0] PORT_SMASK  = 4'h9;
    localparam logic [3:0] PORT_MODE   = 4'hA;
    localparam logic [3:0] PORT_PTRCLR = 4'hB;
    localparam logic [3:0] PORT_AMASK  = 4'hC;
endpackage

// File: rtl/dmac_hostif.sv
// Host port decoder and the shared low/high byte pointer.
// Turns single-cycle strobes into per-channel write enables.
// Assumes ports 0..7 are channel words and strobes last one cycle.
module dmac_hostif #(
    parameter int NCH = dmac_pkg::NCH
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           io_cs,
    input  logic           io_wr,
    input  logic           io_rd,
    input  logic [3:0]     io_addr,
    input  logic [1:0]     sel_field,
    output logic           byte_hi,
    output logic [NCH-1:0] addr_we,
    output logic [NCH-1:0] cnt_we,
    output logic [NCH-1:0] mode_we,
    output logic           smask_we,
    output logic           amask_we,
    output logic           status_rd
);
    logic wr_s, rd_s, word_acc, ptr_clr;

    assign wr_s      = io_cs && io_wr;
    assign rd_s      = io_cs && io_rd;
    assign word_acc  = (wr_s || rd_s) && !io_addr[3];
    assign ptr_clr   = wr_s && (io_addr == dmac_pkg::PORT_PTRCLR);
    assign smask_we  = wr_s && (io_addr == dmac_pkg::PORT_SMASK);
    assign amask_we  = wr_s && (io_addr == dmac_pkg::PORT_AMASK);
    assign status_rd = rd_s && (io_addr == dmac_pkg::PORT_STATUS);

    // Per-channel write enables for address, count and mode.
    for (genvar g = 0; g < NCH; g++) begin : g_dec
        assign addr_we[g] = wr_s && !io_addr[3] && (io_addr[2:1] == 2'(g)) && !io_addr[0];
        assign cnt_we[g]  = wr_s && !io_addr[3] && (io_addr[2:1] == 2'(g)) &&  io_addr[0];
        assign mode_we[g] = wr_s && (io_addr == dmac_pkg::PORT_MODE) && (sel_field == 2'(g));
    end

    // Byte pointer: cleared by the dedicated port, toggled by word accesses.
    always_ff @(posedge clk) begin
        if (!rst_n)        byte_hi <= 1'b0;
        else if (ptr_clr)  byte_hi <= 1'b0;
        else if (word_acc) byte_hi <= !byte_hi;
    end
endmodule

// File: rtl/dmac_channel.sv
// One channel: base and current address/count, mode, stepping.
// Host writes load a byte into base and make current equal to base.
// Assumes WORD_W is 16 (two byte lanes) and step is one cycle.
module dmac_channel #(
    parameter int WORD_W = dmac_pkg::WORD_W,
    parameter int MODE_W = dmac_pkg::MODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_we,
    input  logic              cnt_we,
    input  logic              byte_hi,
    input  logic [7:0]        wdata,
    input  logic              mode_we,
    input  logic              step,
    output logic [WORD_W-1:0] base_addr,
    output logic [WORD_W-1:0] base_cnt,
    output logic [WORD_W-1:0] cur_addr,
    output logic [WORD_W-1:0] cur_cnt,
    output logic [MODE_W-1:0] mode_bits,
    output logic              autoinit,
    output logic              tc
);
    dmac_pkg::mode_t mode_q;
    logic [WORD_W-1:0] addr_wr, cnt_wr;

    // Merge the incoming byte into the lane the pointer selects.
    function automatic logic [WORD_W-1:0] put_byte(input logic [WORD_W-1:0] w,
                                                   input logic hi, input logic [7:0] b);
        logic [WORD_W-1:0] r;
        r = w;
        if (hi) r[WORD_W-1:8] = b;
        else    r[7:0]        = b;
        return r;
    endfunction

    assign addr_wr   = put_byte(base_addr, byte_hi, wdata);
    assign cnt_wr    = put_byte(base_cnt,  byte_hi, wdata);
    assign tc        = step && (cur_cnt == '0);
    assign autoinit  = mode_q.autoinit;
    assign mode_bits = mode_q;

    // Base registers: change only on host writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_addr <= '0;
            base_cnt  <= '0;
        end else begin
            if (addr_we) base_addr <= addr_wr;
            if (cnt_we)  base_cnt  <= cnt_wr;
        end
    end

    // Current address: host write, reload on auto-init TC, or step.
    always_ff @(posedge clk) begin
        if (!rst_n)                     cur_addr <= '0;
        else if (addr_we)               cur_addr <= addr_wr;
        else if (tc && mode_q.autoinit) cur_addr <= base_addr;
        else if (step && mode_q.down)   cur_addr <= cur_addr - 1'b1;
        else if (step)                  cur_addr <= cur_addr + 1'b1;
    end

    // Current count: host write, reload on auto-init TC, or step down.
    always_ff @(posedge clk) begin
        if (!rst_n)                     cur_cnt <= '0;
        else if (cnt_we)                cur_cnt <= cnt_wr;
        else if (tc && mode_q.autoinit) cur_cnt <= base_cnt;
        else if (step)                  cur_cnt <= cur_cnt - 1'b1;
    end

    // Mode register: loaded from data bits [7:2].
    always_ff @(posedge clk) begin
        if (!rst_n)       mode_q <= '0;
        else if (mode_we) mode_q <= wdata[7:2];
    end
endmodule

// File: rtl/dmac_regfile.sv
// Top of the DMA register file: decoder, channels, mask, status, read mux.
// Assumes NCH <= 4 so that status and mask fit one byte.
module dmac_regfile #(
    parameter int NCH    = dmac_pkg::NCH,
    parameter int WORD_W = dmac_pkg::WORD_W,
    parameter int MODE_W = dmac_pkg::MODE_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  io_cs,
    input  logic                  io_wr,
    input  logic                  io_rd,
    input  logic [3:0]            io_addr,
    input  logic [7:0]            io_wdata,
    output logic [7:0]            io_rdata,
    output logic [NCH*WORD_W-1:0] ch_base_addr,
    output logic [NCH*WORD_W-1:0] ch_base_count,
    output logic [NCH-1:0]        ch_mask,
    output logic [NCH*MODE_W-1:0] ch_mode,
    input  logic [NCH-1:0]        ch_req,
    output logic [NCH-1:0]        ch_req_ok,
    input  logic [NCH-1:0]        ch_step,
    output logic [NCH-1:0]        ch_tc
);
    logic                  byte_hi, smask_we, amask_we, status_rd;
    logic [NCH-1:0]        addr_we, cnt_we, mode_we, autoinit;
    logic [NCH-1:0]        mask_nxt, tc_flags;
    logic [WORD_W-1:0]     cur_addr [NCH];
    logic [WORD_W-1:0]     cur_cnt  [NCH];
    logic [NCH*WORD_W-1:0] cur_cnt_flat;
    logic [WORD_W-1:0]     rd_word;
    logic [1:0]            rd_ch;

    dmac_hostif #(.NCH(NCH)) u_host (
        .clk(clk), .rst_n(rst_n), .io_cs(io_cs), .io_wr(io_wr), .io_rd(io_rd),
        .io_addr(io_addr), .sel_field(io_wdata[1:0]), .byte_hi(byte_hi),
        .addr_we(addr_we), .cnt_we(cnt_we), .mode_we(mode_we),
        .smask_we(smask_we), .amask_we(amask_we), .status_rd(status_rd)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        dmac_channel #(.WORD_W(WORD_W), .MODE_W(MODE_W)) u_ch (
            .clk(clk), .rst_n(rst_n),
            .addr_we(addr_we[g]), .cnt_we(cnt_we[g]), .byte_hi(byte_hi),
            .wdata(io_wdata), .mode_we(mode_we[g]), .step(ch_step[g]),
            .base_addr(ch_base_addr[g*WORD_W +: WORD_W]),
            .base_cnt(ch_base_count[g*WORD_W +: WORD_W]),
            .cur_addr(cur_addr[g]), .cur_cnt(cur_cnt[g]),
            .mode_bits(ch_mode[g*MODE_W +: MODE_W]),
            .autoinit(autoinit[g]), .tc(ch_tc[g])
        );
        assign cur_cnt_flat[g*WORD_W +: WORD_W] = cur_cnt[g];
    end

    assign ch_req_ok = ch_req & ~ch_mask;

    // Next mask: all-mask write, then single write, then TC auto-mask.
    always_comb begin
        mask_nxt = ch_mask;
        if (amask_we) mask_nxt = io_wdata[NCH-1:0];
        for (int i = 0; i < NCH; i++) begin
            if (smask_we && (io_wdata[1:0] == 2'(i))) mask_nxt[i] = io_wdata[2];
        end
        mask_nxt = mask_nxt | (ch_tc & ~autoinit);
    end

    // Mask register: every channel masked out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) ch_mask <= '1;
        else        ch_mask <= mask_nxt;
    end

    // Terminal-count flags: cleared by a status read, a new TC wins.
    always_ff @(posedge clk) begin
        if (!rst_n) tc_flags <= '0;
        else        tc_flags <= (status_rd ? '0 : tc_flags) | ch_tc;
    end

    assign rd_ch   = io_addr[2:1];
    assign rd_word = io_addr[0] ? cur_cnt[rd_ch] : cur_addr[rd_ch];

    // Read data: current word byte, status or mask, else zero.
    always_comb begin
        io_rdata = '0;
        if (io_cs && io_rd) begin
            if (!io_addr[3])
                io_rdata = byte_hi ? rd_word[WORD_W-1:8] : rd_word[7:0];
            else if (io_addr == dmac_pkg::PORT_STATUS)
                io_rdata = {4'(ch_req_ok), 4'(tc_flags)};
            else if (io_addr == dmac_pkg::PORT_AMASK)
                io_rdata = {4'b0000, 4'(ch_mask)};
        end
    end
endmodule

// Checker: temporal properties of the register file, bound below.
module dmac_regfile_chk #(
    parameter int NCH    = dmac_pkg::NCH,
    parameter int WORD_W = dmac_pkg::WORD_W,
    parameter int MODE_W = dmac_pkg::MODE_W
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  io_cs,
    input logic                  io_wr,
    input logic                  io_rd,
    input logic [3:0]            io_addr,
    input logic                  byte_hi,
    input logic                  status_rd,
    input logic [NCH-1:0]        ch_mask,
    input logic [NCH*MODE_W-1:0] ch_mode,
    input logic [NCH-1:0]        ch_req,
    input logic [NCH-1:0]        ch_req_ok,
    input logic [NCH-1:0]        ch_step,
    input logic [NCH-1:0]        ch_tc,
    input logic [NCH-1:0]        tc_flags,
    input logic [NCH*WORD_W-1:0] cur_cnt_flat
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (ch_mask == '1 && tc_flags == '0 && !byte_hi));

    // R3
    ptr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_cs && io_wr && io_addr == dmac_pkg::PORT_PTRCLR) |=> !byte_hi);

    // R4
    ptr_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_cs && (io_wr || io_rd) && !io_addr[3]) |=> (byte_hi != $past(byte_hi)));

    // R12
    req_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ch_req_ok & ch_mask) == '0) && ((ch_req_ok & ~ch_req) == '0));

    for (genvar g = 0; g < NCH; g++) begin : g_prop
        // R9
        tc_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ch_tc[g] |=> tc_flags[g]);

        // R9
        tc_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ch_tc[g] |-> (ch_step[g] && cur_cnt_flat[g*WORD_W +: WORD_W] == '0));

        // R11
        tc_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_tc[g] && !ch_mode[g*MODE_W + 2]) |=> ch_mask[g]);

        // R10
        status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (status_rd && !ch_tc[g]) |=> !tc_flags[g]);

        // R8
        count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_step[g] && !ch_tc[g] && !(io_cs && io_wr && io_addr == 4'(2*g+1)))
            |=> (cur_cnt_flat[g*WORD_W +: WORD_W] ==
                 WORD_W'($past(cur_cnt_flat[g*WORD_W +: WORD_W]) - 1'b1)));
    end
endmodule

bind dmac_regfile dmac_regfile_chk #(.NCH(NCH), .WORD_W(WORD_W), .MODE_W(MODE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .io_cs(io_cs), .io_wr(io_wr), .io_rd(io_rd),
    .io_addr(io_addr), .byte_hi(byte_hi), .status_rd(status_rd),
    .ch_mask(ch_mask), .ch_mode(ch_mode), .ch_req(ch_req), .ch_req_ok(ch_req_ok),
    .ch_step(ch_step), .ch_tc(ch_tc), .tc_flags(tc_flags), .cur_cnt_flat(cur_cnt_flat)
);

// File: tb/dmac_regfile_test.sv
`timescale 1ns/1ps
// Scoreboard bench: read tasks queue expected bytes, a monitor compares.
module dmac_regfile_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_cs = 1'b0, io_wr = 1'b0, io_rd = 1'b0;
    logic [3:0]  io_addr = '0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic [63:0] ch_base_addr, ch_base_count;
    logic [3:0]  ch_mask, ch_req = '0, ch_req_ok, ch_step = '0, ch_tc;
    logic [23:0] ch_mode;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [7:0] val;
        string      tag;
    } exp_t;
    exp_t exp_q[$];

    always #4 clk = ~clk;

    dmac_regfile uut (
        .clk(clk), .rst_n(rst_n), .io_cs(io_cs), .io_wr(io_wr), .io_rd(io_rd),
        .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .ch_base_addr(ch_base_addr), .ch_base_count(ch_base_count),
        .ch_mask(ch_mask), .ch_mode(ch_mode), .ch_req(ch_req),
        .ch_req_ok(ch_req_ok), .ch_step(ch_step), .ch_tc(ch_tc)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // Monitor: pops one expected byte per read strobe.
    always @(negedge clk) begin
        #2;
        if (io_cs && io_rd) begin
            if (exp_q.size() == 0) chk("scoreboard underrun", 32'(io_rdata), 32'hFFFF_FFFF);
            else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(e.tag, 32'(io_rdata), 32'(e.val));
            end
        end
    end

    task automatic io_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        io_cs = 1'b1; io_wr = 1'b1; io_addr = a; io_wdata = d;
        @(negedge clk);
        io_cs = 1'b0; io_wr = 1'b0;
    endtask

    task automatic io_read(input logic [3:0] a, input logic [7:0] e, input string tag);
        @(negedge clk);
        io_cs = 1'b1; io_rd = 1'b1; io_addr = a;
        exp_q.push_back('{val: e, tag: tag});
        @(negedge clk);
        io_cs = 1'b0; io_rd = 1'b0;
    endtask

    // One step pulse; the TC output is checked inside the pulse cycle.
    task automatic step(input int ch, input logic [3:0] exp_tc, input string tag);
        @(negedge clk);
        ch_step = 4'b0001 << ch;
        #2;
        chk(tag, 32'(ch_tc), 32'(exp_tc));
        @(negedge clk);
        ch_step = '0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        chk("watchdog expired", 32'd1, 32'd0);
        report();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 mask after reset", 32'(ch_mask), 32'hF);
        chk("R1 base addr after reset", ch_base_addr[31:0], 32'h0);
        io_read(4'h8, 8'h00, "R1 status after reset");
        io_read(4'h2, 8'h00, "R1 ch1 current addr low after reset");
        io_read(4'h2, 8'h00, "R1 ch1 current addr high after reset");

        // R2: program ch1 address 0x1234, count 2 (three transfers)
        io_write(4'h2, 8'h34); io_write(4'h2, 8'h12);
        io_write(4'h3, 8'h02); io_write(4'h3, 8'h00);
        #1;
        chk("R2 ch1 base addr", 32'(ch_base_addr[31:16]), 32'h1234);
        chk("R2 ch1 base count", 32'(ch_base_count[31:16]), 32'h0002);
        io_read(4'h2, 8'h34, "R4 ch1 addr low");
        io_read(4'h2, 8'h12, "R4 ch1 addr high");

        // R3: stray low byte, clear pointer, rewrite
        io_write(4'h4, 8'hAA);
        io_write(4'hB, 8'h5C);
        io_write(4'h4, 8'h11); io_write(4'h4, 8'h22);
        #1;
        chk("R3 ch2 base addr after pointer clear", 32'(ch_base_addr[47:32]), 32'h2211);
        // R4: pointer shared between read and write
        io_read(4'h4, 8'h11, "R4 ch2 low read");
        io_write(4'h4, 8'h99);
        #1;
        chk("R4 write after low read hits high byte", 32'(ch_base_addr[47:32]), 32'h9911);

        // R7: ch1 single, increment, no auto-init, read direction
        io_write(4'hA, 8'h49);
        #1;
        chk("R7 ch1 mode bits", 32'(ch_mode[11:6]), 32'h12);
        chk("R7 other channel mode untouched", 32'(ch_mode[5:0]), 32'h00);

        // R5 / R12: unmask ch1, raise all requests
        io_write(4'h9, 8'h01);
        ch_req = 4'hF;
        #1;
        chk("R5 single clear ch1", 32'(ch_mask), 32'hD);
        chk("R12 only unmasked request passes", 32'(ch_req_ok), 32'h2);

        // R8: one step
        step(1, 4'h0, "R9 no TC on first step");
        io_read(4'h2, 8'h35, "R8 ch1 addr low after step");
        io_read(4'h2, 8'h12, "R8 ch1 addr high after step");
        io_read(4'h3, 8'h01, "R8 ch1 count low after step");
        io_read(4'h3, 8'h00, "R8 ch1 count high after step");
        #1;
        chk("R8 base addr unchanged by step", 32'(ch_base_addr[31:16]), 32'h1234);

        // R9 / R11: third step terminates, no auto-init
        step(1, 4'h0, "R9 no TC on second step");
        step(1, 4'h2, "R9 TC pulse on third step");
        #1;
        chk("R11 mask set after TC without auto-init", 32'(ch_mask), 32'hF);
        io_read(4'h8, 8'h02, "R10 status shows ch1 TC");
        io_read(4'h8, 8'h00, "R10 status cleared by read");
        io_read(4'h3, 8'hFF, "R11 count passes zero low");
        io_read(4'h3, 8'hFF, "R11 count passes zero high");

        // R11: ch0 auto-init, decrement, count 1
        io_write(4'h0, 8'h00); io_write(4'h0, 8'h10);
        io_write(4'h1, 8'h01); io_write(4'h1, 8'h00);
        io_write(4'hA, 8'h34);
        io_write(4'h9, 8'h00);
        step(0, 4'h0, "R9 ch0 first step no TC");
        io_read(4'h0, 8'hFF, "R8 decrement addr low");
        io_read(4'h0, 8'h0F, "R8 decrement addr high");
        step(0, 4'h1, "R9 ch0 TC on second step");
        io_read(4'h0, 8'h00, "R11 auto-init reload addr low");
        io_read(4'h0, 8'h10, "R11 auto-init reload addr high");
        io_read(4'h1, 8'h01, "R11 auto-init reload count low");
        io_read(4'h1, 8'h00, "R11 auto-init reload count high");
        #1;
        chk("R11 auto-init keeps mask", 32'(ch_mask), 32'hE);
        io_read(4'h8, 8'h11, "R10 status TC ch0 and request ch0");

        // R6: all-mask writes, upper nibble ignored
        io_write(4'hC, 8'h05);
        #1;
        chk("R6 all-mask 0101", 32'(ch_mask), 32'h5);
        chk("R12 requests follow all-mask", 32'(ch_req_ok), 32'hA);
        io_write(4'hC, 8'hFA);
        io_read(4'hC, 8'h0A, "R6 all-mask readback, high nibble ignored");

        // R10: status read in the same cycle as a terminal step
        step(0, 4'h0, "R9 ch0 step to zero");
        @(negedge clk);
        ch_step = 4'h1; io_cs = 1'b1; io_rd = 1'b1; io_addr = 4'h8;
        exp_q.push_back('{val: 8'h50, tag: "R10 status before same-cycle TC"});
        @(negedge clk);
        ch_step = '0; io_cs = 1'b0; io_rd = 1'b0;
        io_read(4'h8, 8'h51, "R10 TC in read cycle survives");
        io_read(4'h8, 8'h50, "R10 cleared afterwards");

        // R5: single set
        io_write(4'h9, 8'h06);
        #1;
        chk("R5 single set ch2", 32'(ch_mask), 32'hE);

        @(negedge clk);
        chk("scoreboard drained", 32'(exp_q.size()), 32'd0);
        report();
        $finish;
    end
endmodule